// File: doc/BRIEF.md
# Two-Level Hardwired Instruction Sequencer

This block is the hardwired control sequencer of a small 32-bit load/store processor. Two small registers set the control strobes on every clock. A 2-bit machine-cycle register holds the major state, and a 2-bit step counter holds the position inside that machine cycle. Together they select which control points fire. The instruction class, taken from the opcode type field, decides which machine cycles an instruction passes through. A functional or sequencing instruction finishes in one fetch cycle. A load or store adds an execute cycle. A pending interrupt adds an interrupt cycle.

The data path, the ALU and memory sit outside the block. It drives only the strobes that feed them: memory read and write, address-register loads, PC increment, instruction-register load, buffer-register load, register writeback and the jump load. Every pin is a plain level signal sampled on the rising clock. There is no streaming interface, so there is no valid/ready and no back-pressure. The surrounding data path must complete each strobed action within the cycle that carries the strobe.

Top module: `ctl_sequencer`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the unit sits in FETCH at step 0. The only strobes high are `mar_from_pc` and `mem_rd`.
- R2: `step` advances by one on every clock and wraps from 3 to 0. `major_state` uses the codes FETCH=00, INDIRECT=01, EXECUTE=10, INTERRUPT=11. It changes only on the edge that ends step 3, and it never takes the value 01.
- R3: In FETCH, step 0 asserts `mar_from_pc` and `mem_rd`, step 1 asserts `pc_inc`, and step 2 asserts `ir_load`.
- R4: The class comes from `instr_type`: 000 is functional, 101 is transfer, 010 is sequencing. Within a transfer, `instr_func` 0000 is a load and 0001 is a store.
- R5: At FETCH step 3, a functional instruction asserts `rd_from_alu`.
- R6: At FETCH step 3, a load or store asserts `mar_from_alu`, and the next machine cycle is EXECUTE.
- R7: At FETCH step 3, a sequencing instruction asserts `pc_jump` only when `cond_true` is high.
- R8: In EXECUTE the kind captured at FETCH step 3 is used, and the inputs present during EXECUTE are ignored. For a load: `mem_rd` at step 0, then `rd_from_mbr` at step 2. For a store: `mem_wr` at step 0, then `mbr_from_rd` at step 1.
- R9: `irq_req` is sampled only at the end of step 3 of a FETCH (functional or sequencing) or of an EXECUTE. If it is high there, the next cycle is INTERRUPT, otherwise FETCH. At any other step it has no effect.
- R10: INTERRUPT asserts `irq_ack` at step 0 only and then returns to FETCH, whatever `irq_req` is.
- R11: An unrecognised type code, or a transfer function other than 0000 or 0001, asserts `illegal_op` at FETCH step 3 and returns to FETCH.
- R12: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_type | input | 3 | Decoded opcode type field |
| instr_func | input | 4 | Decoded opcode function field |
| cond_true | input | 1 | Branch condition result |
| irq_req | input | 1 | Interrupt request |
| major_state | output | 2 | Current machine cycle |
| step | output | 2 | Current step within the machine cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mar_from_pc | output | 1 | Load address register from PC |
| mar_from_alu | output | 1 | Load address register from Rs1 plus immediate |
| pc_inc | output | 1 | Advance PC by 4 |
| ir_load | output | 1 | Load instruction register from buffer and decode |
| mbr_from_rd | output | 1 | Load buffer register from Rd |
| rd_from_alu | output | 1 | Write Rd from ALU result |
| rd_from_mbr | output | 1 | Write Rd from buffer register |
| pc_jump | output | 1 | Load PC with Rs1 plus immediate |
| irq_ack | output | 1 | Interrupt acknowledge |
| illegal_op | output | 1 | Unrecognised opcode flag |

## Verification
The bench drives a long pseudo-random mix of classes, functions, conditions and interrupt levels, and it changes the inputs every cycle. This goes after three faults:
- A unit that samples the interrupt line at steps 0 to 2 would enter INTERRUPT when it should not.
- A unit that decodes load against store from the live inputs during EXECUTE would swap the read and write strobes.
- A unit that still accepts a transfer with a bad function code would enter EXECUTE instead of flagging it.

A reset in the middle of an execute cycle checks that the captured kind and the step count both return to their starting values.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int STEP_W = 2;
  localparam int TYPE_W = 3;
  localparam int FUNC_W = 4;

  typedef enum logic [1:0] {
    MS_FETCH = 2'b00,
    MS_INDIR = 2'b01,
    MS_EXEC  = 2'b10,
    MS_INTR  = 2'b11
  } major_e;

  typedef enum logic [2:0] {
    CL_FUNC, CL_LOAD, CL_STORE, CL_SEQ, CL_BAD
  } class_e;

  localparam logic [TYPE_W-1:0] TY_FUNC = 3'b000;
  localparam logic [TYPE_W-1:0] TY_XFER = 3'b101;
  localparam logic [TYPE_W-1:0] TY_SEQ  = 3'b010;
  localparam logic [FUNC_W-1:0] FN_LOAD  = 4'd0;
  localparam logic [FUNC_W-1:0] FN_STORE = 4'd1;

  typedef struct packed {
    logic mem_rd, mem_wr, mar_from_pc, mar_from_alu, pc_inc, ir_load;
    logic mbr_from_rd, rd_from_alu, rd_from_mbr, pc_jump, irq_ack, illegal_op;
  } strobe_t;

  function automatic class_e classify(input logic [TYPE_W-1:0] ty,
                                      input logic [FUNC_W-1:0] fn);
    class_e c;
    case (ty)
      TY_FUNC: c = CL_FUNC;
      TY_SEQ:  c = CL_SEQ;
      TY_XFER: c = (fn == FN_LOAD) ? CL_LOAD : (fn == FN_STORE) ? CL_STORE : CL_BAD;
      default: c = CL_BAD;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/seq_timer.sv
module seq_timer
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [STEP_W-1:0] step,
  output logic              last_step
);
  localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else        step <= step + 1'b1;
  end

  assign last_step = (step == STEP_MAX);
endmodule

// File: rtl/seq_major.sv
module seq_major
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   last_step,
  input  class_e cls,
  input  logic   irq_req,
  output major_e major,
  output logic   exe_store
);
  major_e nxt;

  always_comb begin
    nxt = major;
    if (last_step) begin
      case (major)
        MS_FETCH: begin
          case (cls)
            CL_FUNC, CL_SEQ:   nxt = irq_req ? MS_INTR : MS_FETCH;
            CL_LOAD, CL_STORE: nxt = MS_EXEC;
            default:           nxt = MS_FETCH;
          endcase
        end
        MS_EXEC: nxt = irq_req ? MS_INTR : MS_FETCH;
        default: nxt = MS_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      major     <= MS_FETCH;
      exe_store <= 1'b0;
    end else begin
      major <= nxt;
      if (last_step && major == MS_FETCH)
        exe_store <= (cls == CL_STORE);
    end
  end
endmodule

// File: rtl/seq_strobes.sv
module seq_strobes
  import seq_pkg::*;
(
  input  major_e            major,
  input  logic [STEP_W-1:0] step,
  input  class_e            cls,
  input  logic              cond_true,
  input  logic              exe_store,
  output strobe_t           st
);
  logic [3:0] t;

  generate
    for (genvar i = 0; i < 4; i++) begin : g_step
      assign t[i] = (step == STEP_W'(i));
    end
  endgenerate

  always_comb begin
    st = '0;
    case (major)
      MS_FETCH: begin
        st.mar_from_pc  = t[0];
        st.mem_rd       = t[0];
        st.pc_inc       = t[1];
        st.ir_load      = t[2];
        st.rd_from_alu  = t[3] && (cls == CL_FUNC);
        st.mar_from_alu = t[3] && (cls == CL_LOAD || cls == CL_STORE);
        st.pc_jump      = t[3] && (cls == CL_SEQ) && cond_true;
        st.illegal_op   = t[3] && (cls == CL_BAD);
      end
      MS_EXEC: begin
        st.mem_rd      = t[0] && !exe_store;
        st.mem_wr      = t[0] && exe_store;
        st.mbr_from_rd = t[1] && exe_store;
        st.rd_from_mbr = t[2] && !exe_store;
      end
      MS_INTR: st.irq_ack = t[0];
      default: st = '0;
    endcase
  end
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] instr_type,
  input  logic [3:0] instr_func,
  input  logic       cond_true,
  input  logic       irq_req,
  output logic [1:0] major_state,
  output logic [1:0] step,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       mar_from_pc,
  output logic       mar_from_alu,
  output logic       pc_inc,
  output logic       ir_load,
  output logic       mbr_from_rd,
  output logic       rd_from_alu,
  output logic       rd_from_mbr,
  output logic       pc_jump,
  output logic       irq_ack,
  output logic       illegal_op
);
  logic    last_step, exe_store;
  class_e  cls;
  major_e  major;
  strobe_t st;

  assign cls = classify(instr_type, instr_func);

  seq_timer u_timer (.clk(clk), .rst_n(rst_n), .step(step), .last_step(last_step));

  seq_major u_major (.clk(clk), .rst_n(rst_n), .last_step(last_step), .cls(cls),
                     .irq_req(irq_req), .major(major), .exe_store(exe_store));

  seq_strobes u_strobes (.major(major), .step(step), .cls(cls), .cond_true(cond_true),
                         .exe_store(exe_store), .st(st));

  assign major_state  = major;
  assign mem_rd       = st.mem_rd;
  assign mem_wr       = st.mem_wr;
  assign mar_from_pc  = st.mar_from_pc;
  assign mar_from_alu = st.mar_from_alu;
  assign pc_inc       = st.pc_inc;
  assign ir_load      = st.ir_load;
  assign mbr_from_rd  = st.mbr_from_rd;
  assign rd_from_alu  = st.rd_from_alu;
  assign rd_from_mbr  = st.rd_from_mbr;
  assign pc_jump      = st.pc_jump;
  assign irq_ack      = st.irq_ack;
  assign illegal_op   = st.illegal_op;
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] major_state,
  input logic [1:0] step,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       mar_from_alu,
  input logic       irq_ack
);
  a_r2_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> step == 2'($past(step) + 2'd1));

  a_r2_state_held_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    step != 2'd3 |=> $stable(major_state));

  a_r2_no_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    major_state != 2'b01);

  a_r6_transfer_to_execute: assert property (@(posedge clk) disable iff (!rst_n)
    mar_from_alu |=> major_state == 2'b10 && step == 2'd0);

  a_r10_ack_placement: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> major_state == 2'b11 && step == 2'd0);

  a_r10_interrupt_returns: assert property (@(posedge clk) disable iff (!rst_n)
    major_state == 2'b11 && step == 2'd3 |=> major_state == 2'b00);

  a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind ctl_sequencer seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .major_state(major_state), .step(step),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mar_from_alu(mar_from_alu), .irq_ack(irq_ack));

// File: tb/sim_ctl_sequencer.sv
module sim_ctl_sequencer;
  localparam time CLK_PERIOD = 10;
  localparam int  N_CYCLES   = 4000;
  localparam int  WDOG       = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] instr_type;
  logic [3:0] instr_func;
  logic cond_true, irq_req;
  logic [1:0] major_state, step;
  logic mem_rd, mem_wr, mar_from_pc, mar_from_alu, pc_inc, ir_load;
  logic mbr_from_rd, rd_from_alu, rd_from_mbr, pc_jump, irq_ack, illegal_op;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_sequencer u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // bench model
  int em, et;
  bit est;

  task automatic check_reset_state();
    chk(major_state == 2'b00 && step == 2'd0, "R1 state", {major_state, step}, 0);
    chk(mar_from_pc && mem_rd && !mem_wr && !pc_inc && !ir_load && !irq_ack && !illegal_op,
        "R1 strobes", {mar_from_pc, mem_rd, mem_wr, pc_inc, ir_load, irq_ack, illegal_op},
        7'b1100000);
  endtask

  task automatic check_cycle();
    bit f, e, i, isf, isq, isl, iss, bad;
    f = (em == 0); e = (em == 2); i = (em == 3);
    // R4 class codes
    isf = (instr_type == 3'b000);
    isq = (instr_type == 3'b010);
    isl = (instr_type == 3'b101) && (instr_func == 4'd0);
    iss = (instr_type == 3'b101) && (instr_func == 4'd1);
    bad = !(isf || isq || isl || iss);
    chk(major_state == 2'(em) && step == 2'(et), "R2 state/step",
        {major_state, step}, (em << 2) | et);
    chk(mar_from_pc == (f && et == 0) && pc_inc == (f && et == 1) && ir_load == (f && et == 2),
        "R3 fetch strobes", {mar_from_pc, pc_inc, ir_load},
        {f && et == 0, f && et == 1, f && et == 2});
    chk(rd_from_alu == (f && et == 3 && isf), "R5 rd_from_alu", rd_from_alu,
        f && et == 3 && isf);
    chk(mar_from_alu == (f && et == 3 && (isl || iss)), "R6 mar_from_alu", mar_from_alu,
        f && et == 3 && (isl || iss));
    chk(pc_jump == (f && et == 3 && isq && cond_true), "R7 pc_jump", pc_jump,
        f && et == 3 && isq && cond_true);
    chk(mem_rd == ((f && et == 0) || (e && et == 0 && !est)) && mem_wr == (e && et == 0 && est)
        && mbr_from_rd == (e && et == 1 && est) && rd_from_mbr == (e && et == 2 && !est),
        "R8 execute strobes", {mem_rd, mem_wr, mbr_from_rd, rd_from_mbr},
        {(f && et == 0) || (e && et == 0 && !est), e && et == 0 && est,
         e && et == 1 && est, e && et == 2 && !est});
    chk(irq_ack == (i && et == 0), "R10 irq_ack", irq_ack, i && et == 0);
    chk(illegal_op == (f && et == 3 && bad), "R11 illegal_op", illegal_op, f && et == 3 && bad);
    chk(!(mem_rd && mem_wr), "R12 rd/wr exclusive", {mem_rd, mem_wr}, 0);
    // advance the model; R9: irq only matters at step 3
    if (et == 3) begin
      if (f) begin
        if (isl || iss) begin em = 2; est = iss; end
        else if (isf || isq) em = irq_req ? 3 : 0;
        else em = 0;
      end else if (e) em = irq_req ? 3 : 0;
      else em = 0;
    end
    et = (et + 1) % 4;
  endtask

  initial begin
    logic [15:0] r;
    r = 16'hACE1;
    rst_n = 1'b0;
    instr_type = '0; instr_func = '0; cond_true = 1'b0; irq_req = 1'b0;
    repeat (3) @(negedge clk);
    #1 check_reset_state();
    rst_n = 1'b1;
    em = 0; et = 0; est = 0;
    for (int cyc = 0; cyc < N_CYCLES; cyc++) begin
      if (cyc == 2001) begin
        rst_n = 1'b0;
        #1 check_reset_state();
        @(negedge clk);
        #1 check_reset_state();
        rst_n = 1'b1;
        em = 0; et = 0; est = 0;
      end
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      case (r[1:0])
        2'd0: instr_type = 3'b000;
        2'd1: instr_type = 3'b101;
        2'd2: instr_type = 3'b010;
        default: instr_type = r[4:2];
      endcase
      instr_func = r[9] ? {3'b000, r[5]} : r[8:5];
      cond_true  = r[10];
      irq_req    = r[11];
      #1 check_cycle();
      @(negedge clk);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule